// File: doc/BRIEF.md
# Data Transfer Shutdown Controller

This block runs the control side of one data transfer between the bus side and host memory through a data FIFO. A caller pulses `start_i` with a direction bit. The block then drives a control word that turns on the bus enable, the bus-side DMA enable and the host-side DMA enable. It then watches two status inputs: transfer complete and bus phase change.

When the transfer ends, the block runs a fixed shutdown. If the transfer completed normally, it clears all three enables at once. If the phase changed first, it records whether the bus side had finished. For a bus-to-host transfer it then waits for the FIFO to empty. It waits for any host memory request still in flight, and then clears the enables.

After the enables are cleared, the block polls the fed-back host enable until it reads low. When the `DRAIN_WA` parameter is set, it pops one FIFO byte on every poll cycle, so a stalled input latch can drain. Completion is reported with a one-cycle strobe. A sticky flag reports whether the transfer ended by phase mismatch with the bus side not done.

Top module: `dma_term_seq`

## Requirements
- R1: After reset, `ctrl_o` is 0x00, and `busy_o`, `fin_o`, `fifo_pop_o` and `phase_miss_o` are all 0.
- R2: A `start_i` seen while idle loads `ctrl_o` on the next clock. The value is 0x3D when `dir_h2s_i` is 1 (host to bus) and 0x39 when it is 0 (bus to host). In that same cycle `busy_o` rises and `phase_miss_o` clears. Control bit fields: bit0 is the host DMA enable, bit2 is the direction (1 means host to bus), bit3 is the bus DMA enable, bit4 is FIFO reset and bit5 is the bus enable.
- R3: `start_i` has no effect while `busy_o` is 1. `ctrl_o` keeps its value, or follows only the shutdown sequence.
- R4: When `xfer_done_i` is high during the run phase, `ctrl_o` has bits 0, 3 and 5 cleared on the next clock. No FIFO wait and no pending-request wait happen first. `phase_miss_o` stays 0.
- R5: When `phase_mis_i` is high during the run phase and `xfer_done_i` is low, `phase_miss_o` takes the value `!scsi_done_i` on the next clock. `xfer_done_i` has priority over `phase_mis_i`.
- R6: After a phase mismatch in the bus-to-host direction, the block waits until `fifo_empty_i` is 1. In the host-to-bus direction it skips that wait.
- R7: After a phase mismatch, the enables are cleared only on the clock after a cycle in which `mem_req_pend_i` is 0.
- R8: Once the enables are cleared, the block waits while `host_en_fb_i` is 1. On the clock after `host_en_fb_i` is seen low, `fin_o` is high for exactly one cycle and `busy_o` drops.
- R9: With `DRAIN_WA`=1, `fifo_pop_o` is 1 in every wait cycle where `host_en_fb_i` is still 1. With `DRAIN_WA`=0, `fifo_pop_o` is always 0.
- R10: `phase_miss_o` holds its value while idle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a transfer (accepted only when idle) |
| dir_h2s_i | input | 1 | Direction at start: 1 means host to bus |
| xfer_done_i | input | 1 | Transfer count exhausted |
| phase_mis_i | input | 1 | Bus phase changed |
| scsi_done_i | input | 1 | Bus side finished |
| fifo_empty_i | input | 1 | Data FIFO empty |
| mem_req_pend_i | input | 1 | Host memory request in flight |
| host_en_fb_i | input | 1 | Observed host DMA enable |
| ctrl_o | output | 8 | Transfer control word |
| fifo_pop_o | output | 1 | Pop one FIFO byte |
| busy_o | output | 1 | Transfer or shutdown in progress |
| fin_o | output | 1 | One-cycle completion strobe |
| phase_miss_o | output | 1 | Transfer ended by phase miss with bus side not done |

## Verification
The bench goes after priority when `xfer_done_i` and `phase_mis_i` rise together. A design that got this wrong would report a false phase miss or delay shutdown on the FIFO. The bench also checks that the FIFO-empty wait applies in one direction only. Skipping it in the bus-to-host case would cut off data still in the FIFO; applying it to host-to-bus could hang the block. Two more targets are the pending-request wait and the poll on the fed-back enable, where clearing early or strobing `fin_o` before the enable drops shows up one cycle off in the reference model. The bench also sends starts while busy, since a design that accepts them would reload enables during shutdown.

// File: rtl/dma_term_seq.sv
module dma_term_seq #(
  parameter bit DRAIN_WA = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       dir_h2s_i,
  input  logic       xfer_done_i,
  input  logic       phase_mis_i,
  input  logic       scsi_done_i,
  input  logic       fifo_empty_i,
  input  logic       mem_req_pend_i,
  input  logic       host_en_fb_i,
  output logic [7:0] ctrl_o,
  output logic       fifo_pop_o,
  output logic       busy_o,
  output logic       fin_o,
  output logic       phase_miss_o
);
  localparam logic [7:0] CW_H2S  = 8'h3D;
  localparam logic [7:0] CW_S2H  = 8'h39;
  localparam logic [7:0] EN_MASK = 8'h29;

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_FLUSH, S_PEND, S_HALT} st_t;
  st_t st;

  assign busy_o     = (st != S_IDLE);
  assign fifo_pop_o = DRAIN_WA && (st == S_HALT) && host_en_fb_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      ctrl_o       <= 8'h00;
      fin_o        <= 1'b0;
      phase_miss_o <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          ctrl_o       <= dir_h2s_i ? CW_H2S : CW_S2H;
          phase_miss_o <= 1'b0;
          st           <= S_RUN;
        end
        S_RUN: begin
          if (xfer_done_i) begin
            ctrl_o <= ctrl_o & ~EN_MASK;
            st     <= S_HALT;
          end else if (phase_mis_i) begin
            phase_miss_o <= !scsi_done_i;
            st           <= ctrl_o[2] ? S_PEND : S_FLUSH;
          end
        end
        S_FLUSH: if (fifo_empty_i) st <= S_PEND;
        S_PEND: if (!mem_req_pend_i) begin
          ctrl_o <= ctrl_o & ~EN_MASK;
          st     <= S_HALT;
        end
        S_HALT: if (!host_en_fb_i) begin
          st    <= S_IDLE;
          fin_o <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (ctrl_o == CW_H2S || ctrl_o == CW_S2H));
  assert_no_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[0] |=> (ctrl_o == $past(ctrl_o)) || !ctrl_o[0]);
  assert_fin_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o);
  assert_fin_after_fb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |-> $past(!host_en_fb_i) && !busy_o && ((ctrl_o & EN_MASK) == 8'h00));
  assert_pop_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |-> ((ctrl_o & EN_MASK) == 8'h00) && host_en_fb_i);
  assert_miss_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(phase_miss_o));
endmodule

// File: tb/dma_term_seq_test.sv
`timescale 1ns/1ps
module dma_term_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start, dir, xd, pm, sd, fe, mrp, fb;
  logic [7:0] ctrl, ctrl0;
  logic pop, busy, fin, miss, pop0, busy0, fin0, miss0;
  int   nt = 0, nf = 0;
  bit   done_run = 0;

  always #2.5 clk = ~clk;

  dma_term_seq #(.DRAIN_WA(1'b1)) uut (.clk(clk), .rst_n(rst_n), .start_i(start), .dir_h2s_i(dir),
    .xfer_done_i(xd), .phase_mis_i(pm), .scsi_done_i(sd), .fifo_empty_i(fe), .mem_req_pend_i(mrp),
    .host_en_fb_i(fb), .ctrl_o(ctrl), .fifo_pop_o(pop), .busy_o(busy), .fin_o(fin), .phase_miss_o(miss));
  dma_term_seq #(.DRAIN_WA(1'b0)) uut0 (.clk(clk), .rst_n(rst_n), .start_i(start), .dir_h2s_i(dir),
    .xfer_done_i(xd), .phase_mis_i(pm), .scsi_done_i(sd), .fifo_empty_i(fe), .mem_req_pend_i(mrp),
    .host_en_fb_i(fb), .ctrl_o(ctrl0), .fifo_pop_o(pop0), .busy_o(busy0), .fin_o(fin0), .phase_miss_o(miss0));

  // behavioural reference: 0 idle, 1 running, 2 await fifo, 3 await request, 4 await enable drop
  int   m_st = 0;
  int   m_ctrl = 0;
  bit   m_fin = 0, m_miss = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ctrl = 0; m_fin = 0; m_miss = 0;
    end else begin
      m_fin = 0;
      if (m_st == 0) begin
        if (start) begin m_ctrl = dir ? 61 : 57; m_miss = 0; m_st = 1; end
      end else if (m_st == 1) begin
        if (xd) begin m_ctrl = m_ctrl - (m_ctrl % 2) - 8 - 32; m_st = 4; end
        else if (pm) begin m_miss = !sd; m_st = ((m_ctrl / 4) % 2 == 1) ? 3 : 2; end
      end else if (m_st == 2) begin
        if (fe) m_st = 3;
      end else if (m_st == 3) begin
        if (!mrp) begin m_ctrl = m_ctrl - (m_ctrl % 2) - 8 - 32; m_st = 4; end
      end else if (!fb) begin
        m_st = 0; m_fin = 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nt++;
    if (act != exp) begin
      nf++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 R4 R6 R7 ctrl", ctrl, m_ctrl);
    chk("R3 R8 busy", busy, m_st != 0);
    chk("R8 fin", fin, m_fin);
    chk("R5 R10 miss", miss, m_miss);
    chk("R9 pop with drain", pop, (m_st == 4) && fb);
    chk("R9 pop without drain", pop0, 0);
    chk("R9 ctrl without drain", ctrl0, m_ctrl);
  endtask

  initial begin
    #(5.0 * 150000);
    nf++;
    $display("FAIL watchdog actual=hung expected=finished");
    if (!done_run) begin
      $display("[TB] %0d tests run, %0d failed", nt, nf);
      $finish;
    end
  end

  initial begin
    {start, dir, xd, pm, sd, fe, mrp, fb} = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", ctrl, 0); chk("R1 busy", busy, 0); chk("R1 fin", fin, 0);
    chk("R1 pop", pop, 0);   chk("R1 miss", miss, 0);
    rst_n = 1'b1;
    // directed: host-to-bus phase miss with bus side not done (R5, R6 skip)
    start = 1; dir = 1; mrp = 1; fb = 1;
    @(negedge clk); compare_all(); start = 1; pm = 1; sd = 0;
    @(negedge clk); compare_all(); chk("R3 start ignored", ctrl, 8'h3D); pm = 0; start = 0;
    @(negedge clk); compare_all(); mrp = 0;
    @(negedge clk); compare_all(); chk("R7 cleared", ctrl, 8'h14);
    @(negedge clk); compare_all(); chk("R9 drain", pop, 1); fb = 0;
    @(negedge clk); compare_all(); chk("R8 fin", fin, 1); chk("R5 miss", miss, 1);
    // directed: done and phase miss together in bus-to-host direction (R4 priority)
    start = 1; dir = 0; fb = 1;
    @(negedge clk); compare_all(); chk("R10 cleared on start", miss, 0); start = 0; xd = 1; pm = 1;
    @(negedge clk); compare_all(); chk("R4 direct clear", ctrl, 8'h10); xd = 0; pm = 0; fb = 0;
    @(negedge clk); compare_all();
    @(negedge clk); compare_all();
    // random patterns
    for (int i = 0; i < 6000; i++) begin
      start = ($urandom % 4) == 0; dir = $urandom % 2;
      xd = ($urandom % 8) == 0;   pm = ($urandom % 8) == 0;
      sd = $urandom % 2;          fe = ($urandom % 3) == 0;
      mrp = $urandom % 2;         fb = $urandom % 2;
      #0.1; compare_all();
      @(negedge clk);
    end
    compare_all();
    done_run = 1;
    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end
endmodule